// File: doc/BRIEF.md
# Split-Half Multiplexed Delta Sequencer

This block turns a signed 12-bit sample-to-sample difference into a time-multiplexed drive pattern for an external six-input binary-weighted resistor network that charges or discharges an output capacitor. The magnitude is cut into a high six-bit half and a low six-bit half. In each group of 65 clocks, the high half is presented for 64 clocks and the low half for one clock. The two halves therefore land on the capacitor with a 64:1 weight, and a six-input network resolves twelve bits of delta.

A sample period holds `REPEATS` back-to-back groups followed by `IDLE_CYCLES` dummy clocks. The dummy clocks let a standard oscillator frequency fit the sample rate. During them the drive enable is low, and the external tri-state driver leaves the capacitor untouched. The direction line tells the driver whether to pull the network high (charge) or low (discharge). The delta and its sign are captured once, at the first clock of each sample period. All outputs are registered.

Top module: `split_delta_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `net_bits`=0, `half_sel`=0, `dir_up`=0 and `drive_en`=0.
- R2: Slots are counted from the first clock edge with `rst` low, and the outputs follow each edge by one register. In each group, the first 64 slots show `net_bits` = captured magnitude bits [11:6], with `half_sel`=0 and `drive_en`=1.
- R3: The 65th slot of each group shows `net_bits` = captured magnitude bits [5:0], with `half_sel`=1 and `drive_en`=1. It lasts exactly one cycle.
- R4: A sample period contains exactly `REPEATS` groups (default 2), so `half_sel` pulses `REPEATS` times between consecutive idle stretches.
- R5: After the groups, `IDLE_CYCLES` slots follow (default 9). In these slots `drive_en`=0, `net_bits`=0, `half_sel`=0 and `dir_up`=0. The sample period is then `REPEATS*65+IDLE_CYCLES` slots.
- R6: In every active slot, `dir_up` = 1 when the captured `delta_neg` is 0 (charge) and 0 when it is 1 (discharge).
- R7: `delta_mag` and `delta_neg` are sampled only at slot 0 of each sample period. Changes in any other slot have no effect on the outputs until the next period.
- R8: The first clock edge with `rst` low is slot 0. The cycle after it already shows the high half of the delta sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delta_mag | input | 12 | Delta magnitude; sampled at slot 0 |
| delta_neg | input | 1 | Delta sign; 1 = discharge |
| net_bits | output | 6 | Bits driving the resistor network |
| half_sel | output | 1 | 1 while the low half is presented |
| dir_up | output | 1 | 1 = charge, 0 = discharge |
| drive_en | output | 1 | Enable for the external tri-state driver |

## Verification
The assertions assume that the group length is `2**HALF_W+1`. They also assume that reset is synchronous and held for at least one edge, because the run-length counter in the checker starts from reset. No assumption is made about how the delta inputs behave between sample starts: the stimulus deliberately changes them every cycle during some periods, and applies a reset in the middle of a period. The reference model captures the delta at its own slot 0 and flags any later input change as a capture-timing check.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    PH_UPPER = 2'd0,
    PH_LOWER = 2'd1,
    PH_IDLE  = 2'd2
  } phase_e;
endpackage

// File: rtl/sds_slot_timer.sv
module sds_slot_timer
  import sds_pkg::*;
#(
  parameter int HALF_W      = 6,
  parameter int REPEATS     = 2,
  parameter int IDLE_CYCLES = 9
) (
  input  logic   clk,
  input  logic   rst,
  output logic   sample_start,
  output phase_e phase
);
  localparam int GROUP = (1 << HALF_W) + 1;
  localparam int GW    = $clog2(GROUP);
  localparam int RW    = $clog2(REPEATS + 1);

  logic [GW-1:0] grp_cnt;
  logic [RW-1:0] rep_cnt;
  logic          in_idle;
  logic          grp_last;
  logic          last_active;

  assign grp_last    = (grp_cnt == GW'(GROUP - 1));
  assign last_active = !in_idle && grp_last && (rep_cnt == RW'(REPEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_cnt <= '0;
      rep_cnt <= '0;
    end else if (!in_idle) begin
      if (grp_last) begin
        grp_cnt <= '0;
        rep_cnt <= (rep_cnt == RW'(REPEATS - 1)) ? '0 : rep_cnt + 1'b1;
      end else begin
        grp_cnt <= grp_cnt + 1'b1;
      end
    end
  end

  generate
    if (IDLE_CYCLES > 0) begin : g_idle
      localparam int IW = $clog2(IDLE_CYCLES + 1);
      logic [IW-1:0] idle_cnt;
      logic          idle_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          idle_r   <= 1'b0;
          idle_cnt <= '0;
        end else if (idle_r) begin
          if (idle_cnt == IW'(IDLE_CYCLES - 1)) begin
            idle_r   <= 1'b0;
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end else if (last_active) begin
          idle_r <= 1'b1;
        end
      end
      assign in_idle = idle_r;
    end else begin : g_no_idle
      assign in_idle = 1'b0;
    end
  endgenerate

  assign sample_start = !in_idle && (grp_cnt == '0) && (rep_cnt == '0);

  always_comb begin
    if (in_idle)       phase = PH_IDLE;
    else if (grp_last) phase = PH_LOWER;
    else               phase = PH_UPPER;
  end
endmodule

// File: rtl/sds_delta_hold.sv
module sds_delta_hold #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] in_mag,
  input  logic          in_neg,
  output logic [DW-1:0] cur_mag,
  output logic          cur_neg
);
  logic [DW-1:0] held_mag;
  logic          held_neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_mag <= '0;
      held_neg <= 1'b0;
    end else if (capture) begin
      held_mag <= in_mag;
      held_neg <= in_neg;
    end
  end

  assign cur_mag = capture ? in_mag : held_mag;
  assign cur_neg = capture ? in_neg : held_neg;
endmodule

// File: rtl/split_delta_seq.sv
module split_delta_seq
  import sds_pkg::*;
#(
  parameter int HALF_W      = 6,
  parameter int REPEATS     = 2,
  parameter int IDLE_CYCLES = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*HALF_W-1:0]   delta_mag,
  input  logic                  delta_neg,
  output logic [HALF_W-1:0]     net_bits,
  output logic                  half_sel,
  output logic                  dir_up,
  output logic                  drive_en
);
  localparam int DW = 2 * HALF_W;

  logic          sample_start;
  phase_e        phase;
  logic [DW-1:0] cur_mag;
  logic          cur_neg;

  sds_slot_timer #(
    .HALF_W(HALF_W), .REPEATS(REPEATS), .IDLE_CYCLES(IDLE_CYCLES)
  ) u_timer (
    .clk(clk), .rst(rst), .sample_start(sample_start), .phase(phase)
  );

  sds_delta_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .capture(sample_start),
    .in_mag(delta_mag), .in_neg(delta_neg),
    .cur_mag(cur_mag), .cur_neg(cur_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      net_bits <= '0;
      half_sel <= 1'b0;
      dir_up   <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      case (phase)
        PH_UPPER: begin
          net_bits <= cur_mag[DW-1:HALF_W];
          half_sel <= 1'b0;
          dir_up   <= !cur_neg;
          drive_en <= 1'b1;
        end
        PH_LOWER: begin
          net_bits <= cur_mag[HALF_W-1:0];
          half_sel <= 1'b1;
          dir_up   <= !cur_neg;
          drive_en <= 1'b1;
        end
        default: begin
          net_bits <= '0;
          half_sel <= 1'b0;
          dir_up   <= 1'b0;
          drive_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int HALF_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [HALF_W-1:0] net_bits,
  input logic              half_sel,
  input logic              dir_up,
  input logic              drive_en
);
  localparam int UPPER_LEN = 1 << HALF_W;
  logic [HALF_W+1:0] up_run;

  always_ff @(posedge clk) begin
    if (rst)                      up_run <= '0;
    else if (drive_en && !half_sel) up_run <= up_run + 1'b1;
    else                          up_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!drive_en && !half_sel && net_bits == '0 && !dir_up)); // R1
  AST_UPPER_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
    half_sel |-> (up_run == (HALF_W+2)'(UPPER_LEN))); // R2
  AST_UPPER_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    up_run <= (HALF_W+2)'(UPPER_LEN)); // R2
  AST_LOWER_SINGLE: assert property (@(posedge clk) disable iff (rst)
    half_sel |=> !half_sel); // R3
  AST_LOWER_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    half_sel |-> drive_en); // R3
  AST_IDLE_AFTER_LOWER: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_en) |-> $past(half_sel)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (net_bits == '0 && !half_sel && !dir_up)); // R5
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(drive_en) && !$past(half_sel) && !half_sel && drive_en)
      |-> ($stable(net_bits) && $stable(dir_up))); // R7
endmodule

bind split_delta_seq sds_checker #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .net_bits(net_bits), .half_sel(half_sel),
  .dir_up(dir_up), .drive_en(drive_en)
);

// File: tb/split_delta_seq_tb.sv
module split_delta_seq_tb;
  localparam int HALF_W = 6;
  localparam int REPEATS = 2;
  localparam int IDLE_CYCLES = 9;
  localparam int GROUP = (1 << HALF_W) + 1;
  localparam int PERIOD = REPEATS * GROUP + IDLE_CYCLES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*HALF_W-1:0] delta_mag = '0;
  logic delta_neg = 1'b0;
  logic [HALF_W-1:0] net_bits;
  logic half_sel, dir_up, drive_en;

  always #10 clk = ~clk;

  split_delta_seq #(.HALF_W(HALF_W), .REPEATS(REPEATS), .IDLE_CYCLES(IDLE_CYCLES)) u_dut (
    .clk(clk), .rst(rst), .delta_mag(delta_mag), .delta_neg(delta_neg),
    .net_bits(net_bits), .half_sel(half_sel), .dir_up(dir_up), .drive_en(drive_en)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int slot = 0;
  int cap_mag = 0;
  bit cap_neg = 0;
  bit started = 0, first_act = 0, stale = 0;
  int e_bits = 0;
  bit e_half = 0, e_dir = 0, e_en = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      slot = 0; e_bits = 0; e_half = 0; e_dir = 0; e_en = 0; tag = "R1";
      first_act = 1;
    end else begin
      if (slot == 0) begin cap_mag = int'(delta_mag); cap_neg = delta_neg; end
      stale = (slot != 0) && (int'(delta_mag) != cap_mag || delta_neg != cap_neg);
      if (slot >= REPEATS * GROUP) begin
        e_bits = 0; e_half = 0; e_dir = 0; e_en = 0; tag = "R5";
      end else begin
        e_en = 1; e_dir = !cap_neg;
        if ((slot % GROUP) == GROUP - 1) begin
          e_half = 1; e_bits = cap_mag % (1 << HALF_W); tag = "R3";
        end else begin
          e_half = 0; e_bits = cap_mag >> HALF_W; tag = "R2";
        end
        if (stale) tag = "R7";
        if (first_act) tag = "R8";
      end
      first_act = 0;
      slot = (slot + 1) % PERIOD;
    end
    started = 1;
  end

  int lower_cnt = 0;
  bit prev_en = 0;

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(net_bits) != e_bits || half_sel != e_half || drive_en != e_en) begin
        failures++;
        $display("FAIL %s slot-out bits/half/en got %0d/%0b/%0b exp %0d/%0b/%0b",
                 tag, net_bits, half_sel, drive_en, e_bits, e_half, e_en);
      end
      checks++;
      if (dir_up != e_dir) begin
        failures++;
        $display("FAIL R6 dir_up got %0b exp %0b", dir_up, e_dir);
      end
      if (rst) lower_cnt = 0;
      else begin
        if (half_sel) lower_cnt++;
        if (prev_en && !drive_en) begin
          checks++; // R4 groups per sample
          if (lower_cnt != REPEATS) begin
            failures++;
            $display("FAIL R4 groups per sample got %0d exp %0d", lower_cnt, REPEATS);
          end
          lower_cnt = 0;
        end
      end
      prev_en = drive_en;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic set_delta(input int mag, input bit neg);
    delta_mag = (2*HALF_W)'(mag);
    delta_neg = neg;
  endtask

  task automatic run_samples(input int n, input int mag, input bit neg);
    for (int i = 0; i < n * PERIOD; i++) begin
      @(negedge clk);
      if (i == 0) set_delta(mag, neg);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    set_delta('hA5C, 0);
    rst = 0;                               // R8 first slot uses this delta
    run_samples(1, 'hFFF, 1);
    run_samples(1, 'h000, 0);
    run_samples(1, 'h03F, 1);
    run_samples(1, 'hFC0, 0);
    // R7: inputs change every cycle inside the sample periods
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      set_delta(int'($urandom % 4096), 1'($urandom % 2));
    end
    // mid-period reset, R1 again
    repeat (40) @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    set_delta('h5A3, 1);
    rst = 0;
    run_samples(2, 'h801, 0);
    finish_run();
  end
endmodule